// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block is a small control state machine that sits beside a flash array and decides, every clock cycle, what the array may be used for. Software writes a control word made of three bits: verify-enable, program and erase. It also writes a block-select word naming the sectors it will erase. The guard turns these into a visible mode and into four permission outputs: read, verify-read, program and erase. The cell timing, the high-voltage sequencing and the processor itself live outside it.

While a program or erase operation is open, four kinds of misuse are fatal to it:

- a read of the array, which includes instruction fetches and vector reads;
- entry into exception handling;
- execution of a sleep instruction, which includes entry into software standby;
- loss of bus mastership.

Any of these latches a sticky error flag and moves the guard into an error-protection mode. In that mode programming and erasing are blocked but reading stays possible. Only a reset, or a hardware-standby request, clears the flag.

Software standby is tracked in two ways. Without an error, the guard parks with no permissions and returns to normal operation when standby ends. With an error, it parks in an error-protection standby mode that keeps the flag set.

Top module: `flash_pe_guard`

## Requirements
- R1: When `rst_n` or `hstby_n` is low at a clock edge, the next cycle shows `mode`=0, `err_flag`=0, `ctl_q`=0, `blk_q`=0 and all four permissions low. This holds whatever the other inputs are.
- R2: In the first cycle after reset and hardware standby are both released, `mode` is 1 (normal). In normal mode only `can_read` is high.
- R3: An accepted write loads `ctl_q`={ve,p,e} from `ctl_ve`,`ctl_p`,`ctl_e` and loads `blk_q` from `blk_wdata`. The mode then follows the loaded bits:
  - p=1 gives mode 3 (program), where only `can_program` is high;
  - e=1 gives mode 4 (erase), where only `can_erase` is high;
  - ve=1 alone gives mode 2 (read-verify), where `can_read` and `can_verify` are high;
  - all three bits at 0 give mode 1.
- R4: The following writes are ignored and leave `ctl_q`, `blk_q` and `mode` unchanged:
  - a write with both p and e set;
  - a write that sets p or e while ve is 0;
  - any write made while `mode` is 0, 5, 6 or 7.
- R5: `arr_read` high in mode 3 or 4 sets `err_flag`. The guard enters mode 5 (error protection) and keeps `ctl_q` and `blk_q`. In modes 5 and 6 only `can_read` and `can_verify` are high.
- R6: `exc_entry` high in mode 3 or 4 sets `err_flag` and enters mode 5.
- R7: `sleep_exec` or `sstby` high in mode 3 or 4 sets `err_flag`. If `sstby` is high, the guard enters mode 6 (error protection in standby) and clears `ctl_q` and `blk_q`. Otherwise it enters mode 5.
- R8: `bus_lost` high in mode 3 or 4 sets `err_flag` and enters mode 5.
- R9: `err_flag`, once set, stays set through software standby and through writes. Mode 5 with `sstby` high goes to mode 6 and clears `ctl_q` and `blk_q`. Mode 6 with `sstby` low returns to mode 5. Only R1 clears the flag.
- R10: Misuse events in modes 1 and 2 leave `err_flag` at 0 and the mode unchanged.
- R11: `sstby` high in mode 1 or 2 enters mode 7 and clears `ctl_q` and `blk_q`; mode 7 has no permissions. Mode 7 with `sstby` low returns to mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low, highest priority |
| hstby_n | input | 1 | Hardware standby request, active low |
| sstby | input | 1 | Software standby is active |
| ctl_wr | input | 1 | Write strobe for the control and block-select words |
| ctl_ve | input | 1 | Verify-enable bit of the written control word |
| ctl_p | input | 1 | Program bit of the written control word |
| ctl_e | input | 1 | Erase bit of the written control word |
| blk_wdata | input | NBLK | Block-select write data |
| arr_read | input | 1 | Array read, instruction fetch or vector read |
| exc_entry | input | 1 | Exception handling begins (reset excluded) |
| sleep_exec | input | 1 | Sleep instruction executed |
| bus_lost | input | 1 | Processor lost bus mastership |
| mode | output | 3 | Current mode code 0..7 |
| err_flag | output | 1 | Sticky misuse flag |
| ctl_q | output | 3 | Control word {ve,p,e} |
| blk_q | output | NBLK | Block-select word |
| can_read | output | 1 | Array read permitted |
| can_verify | output | 1 | Verify-read permitted |
| can_program | output | 1 | Programming permitted |
| can_erase | output | 1 | Erasing permitted |

## Verification
The bench builds the guard with `NBLK`=4, a narrow width that lets a single distinctive pattern show whether the block-select word is retained or cleared. The mode logic does not depend on `NBLK`, so this width brings every mode transition within reach: each misuse event from both program and erase mode, entry into and release from both standby flavours, and reset or hardware standby arriving on the same cycle as writes and reads.

// File: rtl/flash_pe_guard.sv
module flash_pe_guard #(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hstby_n,
  input  logic            sstby,
  input  logic            ctl_wr,
  input  logic            ctl_ve,
  input  logic            ctl_p,
  input  logic            ctl_e,
  input  logic [NBLK-1:0] blk_wdata,
  input  logic            arr_read,
  input  logic            exc_entry,
  input  logic            sleep_exec,
  input  logic            bus_lost,
  output logic [2:0]      mode,
  output logic            err_flag,
  output logic [2:0]      ctl_q,
  output logic [NBLK-1:0] blk_q,
  output logic            can_read,
  output logic            can_verify,
  output logic            can_program,
  output logic            can_erase
);

  localparam logic [2:0] ST_PROT = 3'd0;
  localparam logic [2:0] ST_RUN  = 3'd1;
  localparam logic [2:0] ST_ERR  = 3'd2;
  localparam logic [2:0] ST_ERRS = 3'd3;
  localparam logic [2:0] ST_STBY = 3'd4;

  localparam logic [2:0] MD_PROT   = 3'd0;
  localparam logic [2:0] MD_NORMAL = 3'd1;
  localparam logic [2:0] MD_VERIFY = 3'd2;
  localparam logic [2:0] MD_PROG   = 3'd3;
  localparam logic [2:0] MD_ERASE  = 3'd4;
  localparam logic [2:0] MD_ERR    = 3'd5;
  localparam logic [2:0] MD_ERRS   = 3'd6;
  localparam logic [2:0] MD_STBY   = 3'd7;

  logic [2:0]      st_q;
  logic            ve_q, p_q, e_q, err_q;
  logic [NBLK-1:0] blk_r;

  wire in_run    = (st_q == ST_RUN);
  wire pe_active = in_run && (p_q || e_q);
  wire misuse    = arr_read || exc_entry || sleep_exec || bus_lost || sstby;
  wire wr_legal  = !(ctl_p && ctl_e) && !((ctl_p || ctl_e) && !ctl_ve);
  wire wr_take   = ctl_wr && in_run && wr_legal;

  always_ff @(posedge clk) begin
    if (!rst_n || !hstby_n) begin
      st_q  <= ST_PROT;
      err_q <= 1'b0;
      ve_q  <= 1'b0;
      p_q   <= 1'b0;
      e_q   <= 1'b0;
      blk_r <= '0;
    end else begin
      case (st_q)
        ST_PROT: st_q <= ST_RUN;
        ST_RUN: begin
          if (pe_active && misuse) begin
            err_q <= 1'b1;
            if (sstby) begin
              st_q  <= ST_ERRS;
              ve_q  <= 1'b0;
              p_q   <= 1'b0;
              e_q   <= 1'b0;
              blk_r <= '0;
            end else begin
              st_q <= ST_ERR;
            end
          end else if (sstby) begin
            st_q  <= ST_STBY;
            ve_q  <= 1'b0;
            p_q   <= 1'b0;
            e_q   <= 1'b0;
            blk_r <= '0;
          end else if (wr_take) begin
            ve_q  <= ctl_ve;
            p_q   <= ctl_p;
            e_q   <= ctl_e;
            blk_r <= blk_wdata;
          end
        end
        ST_ERR: begin
          if (sstby) begin
            st_q  <= ST_ERRS;
            ve_q  <= 1'b0;
            p_q   <= 1'b0;
            e_q   <= 1'b0;
            blk_r <= '0;
          end
        end
        ST_ERRS: if (!sstby) st_q <= ST_ERR;
        ST_STBY: if (!sstby) st_q <= ST_RUN;
        default: st_q <= ST_PROT;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_RUN:  mode = p_q ? MD_PROG : e_q ? MD_ERASE : ve_q ? MD_VERIFY : MD_NORMAL;
      ST_ERR:  mode = MD_ERR;
      ST_ERRS: mode = MD_ERRS;
      ST_STBY: mode = MD_STBY;
      default: mode = MD_PROT;
    endcase
  end

  assign can_read    = (mode == MD_NORMAL) || (mode == MD_VERIFY) ||
                       (mode == MD_ERR) || (mode == MD_ERRS);
  assign can_verify  = (mode == MD_VERIFY) || (mode == MD_ERR) || (mode == MD_ERRS);
  assign can_program = (mode == MD_PROG);
  assign can_erase   = (mode == MD_ERASE);

  assign err_flag = err_q;
  assign ctl_q    = {ve_q, p_q, e_q};
  assign blk_q    = blk_r;

endmodule

module flash_pe_guard_chk #(
  parameter int NBLK = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hstby_n,
  input logic            sstby,
  input logic            ctl_wr,
  input logic            ctl_p,
  input logic            ctl_e,
  input logic            arr_read,
  input logic            exc_entry,
  input logic [2:0]      mode,
  input logic            err_flag,
  input logic [2:0]      ctl_q,
  input logic [NBLK-1:0] blk_q,
  input logic            can_read,
  input logic            can_verify,
  input logic            can_program,
  input logic            can_erase
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    (!rst_n || !hstby_n) |=> (mode == 3'd0 && !err_flag && ctl_q == 3'd0 && blk_q == '0));

  assert_both_bits_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n || !hstby_n)
    (ctl_wr && ctl_p && ctl_e && !sstby) |=> $stable(ctl_q));

  assert_read_in_pe_R5: assert property (@(posedge clk) disable iff (!rst_n || !hstby_n)
    ((mode == 3'd3 || mode == 3'd4) && arr_read && !sstby) |=> (err_flag && mode == 3'd5));

  assert_error_perms_R5: assert property (@(posedge clk) disable iff (!rst_n || !hstby_n)
    (mode == 3'd5 || mode == 3'd6) |-> (can_read && can_verify && !can_program && !can_erase));

  assert_exc_in_pe_R6: assert property (@(posedge clk) disable iff (!rst_n || !hstby_n)
    ((mode == 3'd3 || mode == 3'd4) && exc_entry && !sstby) |=> (err_flag && mode == 3'd5));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n || !hstby_n)
    err_flag |=> err_flag);

  assert_quiet_outside_pe_R10: assert property (@(posedge clk) disable iff (!rst_n || !hstby_n)
    ((mode == 3'd1 || mode == 3'd2) && !err_flag) |=> !err_flag);

endmodule

bind flash_pe_guard flash_pe_guard_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .hstby_n(hstby_n), .sstby(sstby), .ctl_wr(ctl_wr),
  .ctl_p(ctl_p), .ctl_e(ctl_e), .arr_read(arr_read), .exc_entry(exc_entry),
  .mode(mode), .err_flag(err_flag), .ctl_q(ctl_q), .blk_q(blk_q),
  .can_read(can_read), .can_verify(can_verify), .can_program(can_program),
  .can_erase(can_erase)
);

// File: tb/flash_pe_guard_test.sv
module flash_pe_guard_test;
  localparam int NBLK = 4;
  localparam int NV = 42;

  // {rst_n, hstby_n, wr ve p e, rd exc slp bus sws, exp_mode, exp_err}
  localparam logic [14:0] VEC [NV] = '{
    15'b0_1_0000_00000_000_0, // R1
    15'b1_1_0000_00000_001_0, // R2
    15'b1_1_1100_00000_010_0, // R3
    15'b1_1_1110_00000_011_0, // R3
    15'b1_1_1111_00000_011_0, // R4
    15'b1_1_1100_00000_010_0, // R3
    15'b1_1_1101_00000_100_0, // R3
    15'b1_1_1100_00000_010_0, // R3
    15'b1_1_0000_10000_010_0, // R10
    15'b1_1_1110_00000_011_0, // R3
    15'b1_1_0000_10000_101_1, // R5
    15'b1_1_1100_00000_101_1, // R9
    15'b1_1_0000_00001_110_1, // R9
    15'b1_1_0000_00000_101_1, // R9
    15'b1_0_0000_00000_000_0, // R1
    15'b1_1_0000_00000_001_0, // R2
    15'b1_1_1101_00000_100_0, // R3
    15'b1_1_0000_01000_101_1, // R6
    15'b0_1_0000_00000_000_0, // R1
    15'b1_1_0000_00000_001_0, // R2
    15'b1_1_1110_00000_011_0, // R3
    15'b1_1_0000_00010_101_1, // R8
    15'b0_1_0000_00000_000_0, // R1
    15'b1_1_0000_00000_001_0, // R2
    15'b1_1_1110_00000_011_0, // R3
    15'b1_1_0000_00101_110_1, // R7
    15'b1_1_0000_00001_110_1, // R9
    15'b1_1_0000_00000_101_1, // R9
    15'b0_1_0000_00000_000_0, // R1
    15'b1_1_0000_00000_001_0, // R2
    15'b1_1_0000_00001_111_0, // R11
    15'b1_1_0000_00000_001_0, // R11
    15'b1_1_1010_00000_001_0, // R4
    15'b0_1_1100_10000_000_0, // R1
    15'b1_1_0000_00000_001_0, // R2
    15'b1_1_1110_00000_011_0, // R3
    15'b1_1_0000_00100_101_1, // R7
    15'b0_1_0000_00000_000_0, // R1
    15'b1_1_0000_00000_001_0, // R2
    15'b1_1_1100_00000_010_0, // R3
    15'b1_1_0000_01000_010_0, // R10
    15'b1_1_1000_00000_001_0  // R3
  };
  localparam int TAG [NV] = '{1,2,3,3,4,3,3,3,10,3,5,9,9,9,1,2,3,6,1,2,3,8,1,2,3,7,9,9,1,2,11,11,4,1,2,3,7,1,2,3,10,3};

  logic clk = 1'b0;
  logic rst_n = 1'b0, hstby_n = 1'b1, sstby = 1'b0;
  logic ctl_wr = 1'b0, ctl_ve = 1'b0, ctl_p = 1'b0, ctl_e = 1'b0;
  logic [NBLK-1:0] blk_wdata = 4'hA;
  logic arr_read = 1'b0, exc_entry = 1'b0, sleep_exec = 1'b0, bus_lost = 1'b0;
  logic [2:0] mode, ctl_q;
  logic [NBLK-1:0] blk_q;
  logic err_flag, can_read, can_verify, can_program, can_erase;
  int applied = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_pe_guard #(.NBLK(NBLK)) uut (.*);

  function automatic logic [3:0] perms_for(input logic [2:0] m);
    case (m)
      3'd1: return 4'b1000;
      3'd2, 3'd5, 3'd6: return 4'b1100;
      3'd3: return 4'b0010;
      3'd4: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] s);
    @(negedge clk);
    {rst_n, hstby_n, ctl_wr, ctl_ve, ctl_p, ctl_e, arr_read, exc_entry, sleep_exec, bus_lost, sstby} = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      applied++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", TAG[i]);
      drive(VEC[i][14:4]);
      check(rq, "mode", mode, VEC[i][3:1]);
      check(rq, "err_flag", err_flag, VEC[i][0]);
      check(rq, "perms", {can_read, can_verify, can_program, can_erase}, perms_for(VEC[i][3:1]));
    end

    // R1: reset state of registers
    drive(11'b0_1_0000_00000);
    check("R1", "ctl_q", ctl_q, 0);
    check("R1", "blk_q", blk_q, 0);
    // R3: accepted write loads block select
    drive(11'b1_1_0000_00000);
    blk_wdata = 4'h9;
    drive(11'b1_1_1101_00000);
    check("R3", "ctl_q", ctl_q, 3'b101);
    check("R3", "blk_q", blk_q, 4'h9);
    // R4: both bits set leaves registers untouched
    blk_wdata = 4'h6;
    drive(11'b1_1_1111_00000);
    check("R4", "ctl_q", ctl_q, 3'b101);
    check("R4", "blk_q", blk_q, 4'h9);
    // R8: bus loss during erase keeps registers
    drive(11'b1_1_0000_00010);
    check("R8", "mode", mode, 5);
    check("R8", "ctl_q", ctl_q, 3'b101);
    check("R8", "blk_q", blk_q, 4'h9);
    // R9: standby from error protection clears registers, flag stays
    drive(11'b1_1_0000_00001);
    check("R9", "ctl_q", ctl_q, 0);
    check("R9", "blk_q", blk_q, 0);
    check("R9", "err_flag", err_flag, 1);
    // R1: hardware standby clears flag
    drive(11'b1_0_0000_00001);
    check("R1", "err_flag", err_flag, 0);
    // R11: standby without error clears registers
    drive(11'b1_1_0000_00000);
    drive(11'b1_1_1100_00000);
    check("R11", "blk_q pre", blk_q, 4'h6);
    drive(11'b1_1_0000_00001);
    check("R11", "mode", mode, 7);
    check("R11", "blk_q", blk_q, 0);
    drive(11'b1_1_1100_00001);
    check("R4", "ctl_q in standby", ctl_q, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule